// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Controller

This block is the decode-stage hazard controller of a five-stage in-order pipeline. Each cycle it compares the destination register of the instruction in the execute stage against the two source register fields of the instruction waiting in decode. If the execute-stage instruction is a load and either source field names the register it will load, the controller freezes the program counter and the fetch/decode register for one cycle and tells the decode/execute register to take all-zero control fields. That puts a bubble into execute, and the consumer is decoded again one cycle later, when forwarding can supply the loaded value.

The controller also takes a taken-branch indication from the decode stage, where the branch compares its two register operands. When a branch is taken it raises a fetch flush, which turns the instruction just fetched into a NOP. The penalty is one instruction slot. A branch in decode can depend on a load in execute, so a stall in the same cycle outranks the flush. The flush is then held as pending and issued in the cycle after the stall.

All pins are plain control levels. There is no streaming interface and no back-pressure beyond the write enables described here.

Top module: `lu_hazard_ctrl`

## Requirements
- R1: `idex_bubble` is 1 in a cycle where `ex_load` is 1, the controller did not stall in the previous cycle, and `ex_dst` equals `id_src_a` or `id_src_b`.
- R2: `pc_wr_en` and `ifid_wr_en` are both 0 in every stall cycle (`idex_bubble` = 1) and both 1 in every other cycle.
- R3: `idex_bubble` is 0 in any cycle where R1's condition does not hold, including when neither source field matches `ex_dst`.
- R4: A stall lasts exactly one cycle. If `idex_bubble` was 1 in the previous cycle, it is 0 in the current cycle even if the hazard inputs are unchanged.
- R5: `if_flush` is 1 in a non-stall cycle where `id_br_taken` is 1. `if_flush` is never 1 in a stall cycle.
- R6: If `id_br_taken` and a stall coincide, `if_flush` is 0 in that cycle and 1 in the following cycle, even if `id_br_taken` has dropped by then.
- R7: After reset is released, with `ex_load` = 0 and `id_br_taken` = 0, the outputs are `pc_wr_en` = 1, `ifid_wr_en` = 1, `idex_bubble` = 0 and `if_flush` = 0.
- R8: When `ex_load` is 0, no stall occurs, whatever the register fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_load | input | 1 | Instruction in execute reads data memory (is a load) |
| ex_dst | input | REG_AW | Register that the execute-stage load writes |
| id_src_a | input | REG_AW | First source register field of the decode-stage instruction |
| id_src_b | input | REG_AW | Second source register field of the decode-stage instruction |
| id_br_taken | input | 1 | Branch in decode resolved as taken |
| pc_wr_en | output | 1 | Program counter write enable |
| ifid_wr_en | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields written into decode/execute |
| if_flush | output | 1 | Replace the fetch/decode instruction with a NOP |

## Verification
The bench applies every combination of load flag, branch flag and three 3-bit register fields. Because the vectors run back to back, the one-cycle stall limit and the pending-flush carry are both exercised many times against a model of those two state bits. A design that compared only one source field would miss half the hazards. A design that repeated the stall while the load sat in execute would freeze fetch for good. A design that dropped a flush coinciding with a stall would let a wrong-path instruction run, and one that flushed during the stall would destroy the held branch.

// File: rtl/lu_hazard_pkg.sv
package lu_hazard_pkg;
  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic bubble;
    logic flush;
  } hz_ctl_t;

  localparam int unsigned N_SRC = 2;
endpackage

// File: rtl/lu_src_match.sv
module lu_src_match #(
  parameter int unsigned AW    = 5,
  parameter int unsigned NSRC  = 2
) (
  input  logic                      load_i,
  input  logic [AW-1:0]             dst_i,
  input  logic [NSRC-1:0][AW-1:0]   src_i,
  output logic                      hit_o
);
  logic [NSRC-1:0] eq;

  for (genvar g = 0; g < NSRC; g++) begin : g_cmp
    assign eq[g] = (src_i[g] == dst_i);
  end

  assign hit_o = load_i & (|eq);
endmodule

// File: rtl/lu_stall_gate.sv
module lu_stall_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  output logic stall_o
);
  logic stalled_q;

  assign stall_o = hit_i & ~stalled_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= stall_o;
  end
endmodule

// File: rtl/lu_flush_seq.sv
module lu_flush_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic stall_i,
  input  logic br_i,
  output logic flush_o
);
  logic pend_q;

  assign flush_o = ~stall_i & (br_i | pend_q);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= stall_i & br_i;
  end
endmodule

// File: rtl/lu_hazard_ctrl.sv
module lu_hazard_ctrl
  import lu_hazard_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_br_taken,
  output logic              pc_wr_en,
  output logic              ifid_wr_en,
  output logic              idex_bubble,
  output logic              if_flush
);
  logic [N_SRC-1:0][REG_AW-1:0] srcs;
  logic    hit, stall, flush;
  hz_ctl_t ctl;

  assign srcs[0] = id_src_a;
  assign srcs[1] = id_src_b;

  lu_src_match #(.AW(REG_AW), .NSRC(N_SRC)) u_match (
    .load_i (ex_load),
    .dst_i  (ex_dst),
    .src_i  (srcs),
    .hit_o  (hit)
  );

  lu_stall_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .stall_o (stall)
  );

  lu_flush_seq u_flush (
    .clk     (clk),
    .rst_n   (rst_n),
    .stall_i (stall),
    .br_i    (id_br_taken),
    .flush_o (flush)
  );

  always_comb begin
    ctl.pc_we   = ~stall;
    ctl.ifid_we = ~stall;
    ctl.bubble  = stall;
    ctl.flush   = flush;
  end

  assign pc_wr_en    = ctl.pc_we;
  assign ifid_wr_en  = ctl.ifid_we;
  assign idex_bubble = ctl.bubble;
  assign if_flush    = ctl.flush;
endmodule

// File: rtl/lu_hazard_ctrl_chk.sv
module lu_hazard_ctrl_chk #(
  parameter int unsigned REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ex_load,
  input logic [REG_AW-1:0] ex_dst,
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic              id_br_taken,
  input logic              pc_wr_en,
  input logic              ifid_wr_en,
  input logic              idex_bubble,
  input logic              if_flush
);
  logic prev_bub;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_bub <= 1'b0;
    else        prev_bub <= idex_bubble;
  end

  p_hazard_stalls_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && !prev_bub && (ex_dst == id_src_a || ex_dst == id_src_b)) |-> idex_bubble);

  p_enables_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!pc_wr_en && !ifid_wr_en));

  p_enables_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !idex_bubble |-> (pc_wr_en && ifid_wr_en));

  p_no_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_dst != id_src_a && ex_dst != id_src_b) |-> !idex_bubble);

  p_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |=> !idex_bubble);

  p_no_flush_in_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> !idex_bubble);

  p_taken_flushes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_br_taken && !idex_bubble) |-> if_flush);

  p_deferred_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_bubble && id_br_taken) |=> if_flush);

  p_no_load_no_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_load |-> !idex_bubble);
endmodule

bind lu_hazard_ctrl lu_hazard_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ex_load(ex_load), .ex_dst(ex_dst),
  .id_src_a(id_src_a), .id_src_b(id_src_b), .id_br_taken(id_br_taken),
  .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en),
  .idex_bubble(idex_bubble), .if_flush(if_flush)
);

// File: tb/test_lu_hazard_ctrl.sv
module test_lu_hazard_ctrl;
  localparam int unsigned AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ex_load = 1'b0;
  logic [AW-1:0] ex_dst = '0;
  logic [AW-1:0] id_src_a = '0;
  logic [AW-1:0] id_src_b = '0;
  logic          id_br_taken = 1'b0;
  logic          pc_wr_en, ifid_wr_en, idex_bubble, if_flush;

  int n_vec = 0;
  int n_bad = 0;
  logic m_stq = 1'b0;
  logic m_pend = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  lu_hazard_ctrl #(.REG_AW(AW)) i_lu_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .ex_load(ex_load), .ex_dst(ex_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_br_taken(id_br_taken),
    .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en),
    .idex_bubble(idex_bubble), .if_flush(if_flush)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (load=%b dst=%0d a=%0d b=%0d br=%b)",
               tag, act, exp, ex_load, ex_dst, id_src_a, id_src_b, id_br_taken);
    end
  endtask

  // Drive one vector on the falling edge, check mid-low-phase, advance the model.
  task automatic apply(input logic ld, input logic [AW-1:0] d,
                       input logic [AW-1:0] a, input logic [AW-1:0] b,
                       input logic br);
    logic e_stall, e_flush;
    @(negedge clk);
    ex_load = ld; ex_dst = d; id_src_a = a; id_src_b = b; id_br_taken = br;
    #5;
    e_stall = ld && ((d == a) || (d == b)) && !m_stq;   // R1 R3 R4 R8
    e_flush = !e_stall && (br || m_pend);               // R5 R6
    chk(idex_bubble, e_stall, ld ? "R1/R3/R4 bubble" : "R8 bubble");
    chk(pc_wr_en, !e_stall, "R2 pc_wr_en");
    chk(ifid_wr_en, !e_stall, "R2 ifid_wr_en");
    chk(if_flush, e_flush, (m_pend ? "R6 if_flush" : "R5 if_flush"));
    m_stq  = e_stall;
    m_pend = e_stall && br;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #5;
    // R7 reset state
    chk(pc_wr_en, 1'b1, "R7 pc_wr_en");
    chk(ifid_wr_en, 1'b1, "R7 ifid_wr_en");
    chk(idex_bubble, 1'b0, "R7 idex_bubble");
    chk(if_flush, 1'b0, "R7 if_flush");

    // R4: hazard held for three cycles -> stall, release, stall
    apply(1'b1, 3'd5, 3'd5, 3'd1, 1'b0);
    apply(1'b1, 3'd5, 3'd5, 3'd1, 1'b0);
    apply(1'b1, 3'd5, 3'd2, 3'd5, 1'b0);
    apply(1'b0, 3'd0, 3'd0, 3'd0, 1'b0);
    // R6: branch coincides with stall, then drops
    apply(1'b1, 3'd3, 3'd4, 3'd3, 1'b1);
    apply(1'b0, 3'd3, 3'd4, 3'd3, 1'b0);
    apply(1'b0, 3'd0, 3'd0, 3'd0, 1'b0);
    // R8: all fields equal, no load
    apply(1'b0, 3'd7, 3'd7, 3'd7, 1'b1);

    // Exhaustive sweep: load, branch, dst, src_a, src_b
    for (int v = 0; v < (1 << (2 + 3*AW)); v++) begin
      apply(v[0], v[2 +: AW], v[2+AW +: AW], v[2+2*AW +: AW], v[1]);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule